// File: doc/BRIEF.md
# Dual 16-bit Down-Counting Timer

This peripheral holds two 16-bit down counters, half A and half B. Each half has its own reload value, compare value, prescaler and prescale compare value. A configuration field chooses one of three layouts. In the split layout the halves run as two independent timers. In the joined layout they form one 32-bit timer, with B holding the upper word. In the calendar layout the joined counter is paced by a divider fed from a slow 32 kHz input.

Each half counts one of two sources: system clock cycles through its prescaler, or rising edges on its own capture pin. Two stop behaviours are available. A one-shot timer halts and drops its enable. A periodic timer reloads itself.

Four event sources feed a raw status register: a timeout and a compare hit for each half. A mask selects which raw bits reach the masked status and the interrupt line. Software removes a raw bit by writing 1 to a clear register. All settings arrive over a plain single-cycle write port.

Top module: `duo_timer`

## Requirements
- R1: After reset both counters read 0xFFFF, the raw and masked status read 0, the interrupt is low, both halves are disabled, the layout is split and the prescale values are 0.
- R2: A half whose enable is 0 never changes its counter, except through a write to its reload register. The enable bits are CTRL bit 0 for A and bit 1 for B.
- R3: With prescale value P, an enabled half running from the system clock takes one counting step every P+1 clocks. The first step comes on the (P+1)th clock edge after the edge that set the enable.
- R4: In one-shot mode (mode value 0), a counting step taken while the counter reads 0 raises the timeout. The counter then stays at 0 and the enable bit of that half clears.
- R5: In periodic mode (mode value 1), a counting step taken while the counter reads 0 raises the timeout and reloads the counter from its reload register.
- R6: Writing a reload register stores the value and loads it into that half's counter on the same edge.
- R7: In the split layout (CFG value 0) the two halves count and time out independently of each other.
- R8: In the joined layout (CFG value 1), {B,A} is one 32-bit down counter. B changes only when A steps from 0x0000 to 0xFFFF. A step at 0 raises status bit 0 and reloads {reload B, reload A}. Status bits 2 and 3 stay 0.
- R9: A compare hit is raised on a counting source event of an enabled half when the counter equals its compare value and the prescale count equals the prescale compare value. It sets status bit 1 for A and bit 3 for B. Status bit 0 is the A timeout and bit 2 is the B timeout.
- R10: In edge mode (mode value 2), rising edges on the half's capture pin are the counting source, and system clocks alone do not move the counter.
- R11: In the calendar layout (CFG value 2), the joined counter takes one step for every RTC_DIV rising edges on the 32 kHz input.
- R12: The masked status equals raw AND mask, and the interrupt is high exactly when the masked status is nonzero.
- R13: Writing 1 to a bit of the clear register clears that raw bit, and bits written 0 keep their value. An event in the same cycle as the clear leaves the bit set.
- R14: Register addresses: CFG 0, CTRL 1, mode A/B 2/3, reload A/B 4/5, compare A/B 6/7, prescale A/B 8/9, prescale compare A/B 10/11, mask 12, clear 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 16 | Register write data |
| cap_a_i | input | 1 | Capture pin of half A |
| cap_b_i | input | 1 | Capture pin of half B |
| rtc_in_i | input | 1 | 32 kHz calendar input |
| cnt_a_o | output | 16 | Counter of half A |
| cnt_b_o | output | 16 | Counter of half B |
| raw_o | output | 4 | Raw status |
| mis_o | output | 4 | Masked status |
| irq_o | output | 1 | Interrupt request |

## Verification
A register write takes effect on the edge that captures it. A counter first moves P+1 edges after the edge that set its enable. A status bit rises one edge after the cycle in which its event is present, so it trails the counter value that caused it by exactly one edge. Capture and calendar edges pass through a two-stage synchronizer before they count, so those results are only sampled after a settled gap. Every other check is taken 1 ns after the precise edge counted from the write edge, once just before the expected change and once at it.

// File: rtl/duo_timer_pkg.sv
package duo_timer_pkg;
  typedef enum logic [1:0] {
    CFG_SPLIT = 2'd0,
    CFG_JOIN  = 2'd1,
    CFG_RTC   = 2'd2
  } cfg_e;

  typedef enum logic [1:0] {
    MD_ONESHOT  = 2'd0,
    MD_PERIODIC = 2'd1,
    MD_EDGE     = 2'd2
  } mode_e;

  localparam int ADR_CFG     = 0;
  localparam int ADR_CTRL    = 1;
  localparam int ADR_MODE_A  = 2;
  localparam int ADR_LOAD_A  = 4;
  localparam int ADR_MATCH_A = 6;
  localparam int ADR_PRE_A   = 8;
  localparam int ADR_PM_A    = 10;
  localparam int ADR_MASK    = 12;
  localparam int ADR_CLR     = 13;

  localparam int NEVT = 4;
endpackage

// File: rtl/dt_edge_sync.sv
module dt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/dt_rtc_div.sv
module dt_rtc_div #(
  parameter int DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic tick_o
);
  localparam int CNTW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(DIV - 1);

  logic [CNTW-1:0] cnt_q;

  assign tick_o = rise_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (rise_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dt_prescale.sv
module dt_prescale #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          ev_i,
  input  logic [PW-1:0] pre_i,
  input  logic [PW-1:0] pmatch_i,
  output logic          tick_o,
  output logic          at_pmatch_o
);
  logic [PW-1:0] pcnt_q;

  assign tick_o      = en_i && ev_i && (pcnt_q >= pre_i);
  assign at_pmatch_o = (pcnt_q == pmatch_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (!en_i)  pcnt_q <= '0;
    else if (tick_o) pcnt_q <= '0;
    else if (ev_i)   pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/dt_irq.sv
module dt_irq #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mis_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q, mask_q, clr_bits;

  assign clr_bits = clr_we_i ? data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | evt_i;
      if (mask_we_i) mask_q <= data_i;
    end
  end

  assign raw_o = raw_q;
  assign mis_o = raw_q & mask_q;
  assign irq_o = |mis_o;
endmodule

// File: rtl/duo_timer.sv
module duo_timer
  import duo_timer_pkg::*;
#(
  parameter int CW      = 16,
  parameter int PW      = 8,
  parameter int AW      = 4,
  parameter int DW      = 16,
  parameter int RTC_DIV = 32768,
  parameter int SYNC    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          cap_a_i,
  input  logic          cap_b_i,
  input  logic          rtc_in_i,
  output logic [CW-1:0] cnt_a_o,
  output logic [CW-1:0] cnt_b_o,
  output logic [3:0]    raw_o,
  output logic [3:0]    mis_o,
  output logic          irq_o
);
  localparam int WW = 2 * CW;

  // arithmetic of one counting step
  function automatic logic [CW-1:0] step_half(input logic [CW-1:0] c,
                                              input logic [CW-1:0] ld,
                                              input logic reload);
    if (c == '0) return reload ? ld : c;
    return c - 1'b1;
  endfunction

  function automatic logic [WW-1:0] step_word(input logic [WW-1:0] c,
                                              input logic [WW-1:0] ld,
                                              input logic reload);
    if (c == '0) return reload ? ld : c;
    return c - 1'b1;
  endfunction

  cfg_e          cfg_q;
  logic [1:0]    en_q;
  mode_e         mode_q  [2];
  logic [CW-1:0] load_q  [2];
  logic [CW-1:0] match_q [2];
  logic [CW-1:0] cnt_q   [2];
  logic [PW-1:0] pre_q   [2];
  logic [PW-1:0] pm_q    [2];

  logic [1:0] run, ev, tick, at_pm, cap_rise, cap_pin;
  logic       rtc_rise, rtc_tick;

  // named events for the checker
  logic joined, rtc_mode, en_a, en_b, a_oneshot, b_oneshot, a_tick;
  logic a_to_evt, a_match_evt, b_to_evt, b_match_evt;
  logic cfg_we, ctrl_we, mask_we, clr_we, ld_a_we, ld_b_we;
  logic [WW-1:0] wide_q, wide_nxt;

  assign cfg_we  = wr_en_i && (wr_addr_i == AW'(ADR_CFG));
  assign ctrl_we = wr_en_i && (wr_addr_i == AW'(ADR_CTRL));
  assign mask_we = wr_en_i && (wr_addr_i == AW'(ADR_MASK));
  assign clr_we  = wr_en_i && (wr_addr_i == AW'(ADR_CLR));
  assign ld_a_we = wr_en_i && (wr_addr_i == AW'(ADR_LOAD_A));
  assign ld_b_we = wr_en_i && (wr_addr_i == AW'(ADR_LOAD_A + 1));

  assign joined    = (cfg_q == CFG_JOIN) || (cfg_q == CFG_RTC);
  assign rtc_mode  = (cfg_q == CFG_RTC);
  assign en_a      = en_q[0];
  assign en_b      = en_q[1];
  assign a_oneshot = (mode_q[0] == MD_ONESHOT);
  assign b_oneshot = (mode_q[1] == MD_ONESHOT);
  assign a_tick    = tick[0];
  assign cap_pin   = {cap_b_i, cap_a_i};

  assign wide_q   = {cnt_q[1], cnt_q[0]};
  assign wide_nxt = step_word(wide_q, {load_q[1], load_q[0]}, !a_oneshot);

  assign a_to_evt    = tick[0] && (joined ? (wide_q == '0) : (cnt_q[0] == '0));
  assign a_match_evt = run[0] && ev[0] && at_pm[0] &&
                       (joined ? (wide_q == {match_q[1], match_q[0]})
                               : (cnt_q[0] == match_q[0]));
  assign b_to_evt    = tick[1] && (cnt_q[1] == '0);
  assign b_match_evt = run[1] && ev[1] && at_pm[1] && (cnt_q[1] == match_q[1]);

  // calendar pacing
  dt_edge_sync #(.STAGES(SYNC)) u_rtc_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (rtc_in_i),
    .rise_o(rtc_rise)
  );

  dt_rtc_div #(.DIV(RTC_DIV)) u_rtc_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(rtc_rise),
    .tick_o(rtc_tick)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic          mode_we, match_we, pre_we, pm_we, ld_we, adv;
    logic [CW-1:0] nxt;

    assign mode_we  = wr_en_i && (wr_addr_i == AW'(ADR_MODE_A + h));
    assign ld_we    = wr_en_i && (wr_addr_i == AW'(ADR_LOAD_A + h));
    assign match_we = wr_en_i && (wr_addr_i == AW'(ADR_MATCH_A + h));
    assign pre_we   = wr_en_i && (wr_addr_i == AW'(ADR_PRE_A + h));
    assign pm_we    = wr_en_i && (wr_addr_i == AW'(ADR_PM_A + h));

    if (h == 0) begin : g_src_a
      assign run[h] = en_q[h];
      assign ev[h]  = rtc_mode ? rtc_tick
                    : ((mode_q[h] == MD_EDGE) ? cap_rise[h] : 1'b1);
    end else begin : g_src_b
      assign run[h] = en_q[h] && !joined;
      assign ev[h]  = (mode_q[h] == MD_EDGE) ? cap_rise[h] : 1'b1;
    end

    dt_edge_sync #(.STAGES(SYNC)) u_cap (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (cap_pin[h]),
      .rise_o(cap_rise[h])
    );

    dt_prescale #(.PW(PW)) u_pre (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (run[h]),
      .ev_i       (ev[h]),
      .pre_i      (pre_q[h]),
      .pmatch_i   (pm_q[h]),
      .tick_o     (tick[h]),
      .at_pmatch_o(at_pm[h])
    );

    assign adv = joined ? tick[0] : tick[h];
    assign nxt = joined ? wide_nxt[h*CW +: CW]
                        : step_half(cnt_q[h], load_q[h], mode_q[h] != MD_ONESHOT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q[h]  <= MD_ONESHOT;
        load_q[h]  <= '1;
        match_q[h] <= '0;
        pre_q[h]   <= '0;
        pm_q[h]    <= '0;
        cnt_q[h]   <= '1;
      end else begin
        if (mode_we)  mode_q[h]  <= mode_e'(wr_data_i[1:0]);
        if (match_we) match_q[h] <= wr_data_i[CW-1:0];
        if (pre_we)   pre_q[h]   <= wr_data_i[PW-1:0];
        if (pm_we)    pm_q[h]    <= wr_data_i[PW-1:0];
        if (ld_we) begin
          load_q[h] <= wr_data_i[CW-1:0];
          cnt_q[h]  <= wr_data_i[CW-1:0];
        end else if (adv) begin
          cnt_q[h]  <= nxt;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_SPLIT;
      en_q  <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_e'(wr_data_i[1:0]);
      if (ctrl_we) begin
        en_q <= wr_data_i[1:0];
      end else begin
        if (a_to_evt && a_oneshot) en_q[0] <= 1'b0;
        if (b_to_evt && b_oneshot) en_q[1] <= 1'b0;
      end
    end
  end

  dt_irq #(.N(NEVT)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    ({b_match_evt, b_to_evt, a_match_evt, a_to_evt}),
    .clr_we_i (clr_we),
    .mask_we_i(mask_we),
    .data_i   (wr_data_i[NEVT-1:0]),
    .raw_o    (raw_o),
    .mis_o    (mis_o),
    .irq_o    (irq_o)
  );

  assign cnt_a_o = cnt_q[0];
  assign cnt_b_o = cnt_q[1];
endmodule

// File: rtl/dt_chk.sv
module dt_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          joined,
  input logic          en_a,
  input logic          a_oneshot,
  input logic          a_tick,
  input logic          a_to_evt,
  input logic          b_to_evt,
  input logic          b_match_evt,
  input logic          ctrl_we,
  input logic          clr_we,
  input logic          ld_a_we,
  input logic          ld_b_we,
  input logic [15:0]   wr_data_i,
  input logic [CW-1:0] cnt_a_o,
  input logic [CW-1:0] cnt_b_o,
  input logic [3:0]    raw_o
);
  // R4
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_to_evt && a_oneshot && !ctrl_we) |=> !en_a);

  // R9
  evt_sets_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_to_evt |=> raw_o[0]);

  // R13
  clear_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we && wr_data_i[0] && !a_to_evt) |=> !raw_o[0]);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!joined && !en_a && !ld_a_we) |=> $stable(cnt_a_o));

  // R8
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (joined && a_tick && (cnt_a_o != '0) && !ld_b_we) |=> $stable(cnt_b_o));

  // R8
  joined_b_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    joined |-> (!b_to_evt && !b_match_evt));
endmodule

bind duo_timer dt_chk #(.CW(CW)) u_dt_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .joined     (joined),
  .en_a       (en_a),
  .a_oneshot  (a_oneshot),
  .a_tick     (a_tick),
  .a_to_evt   (a_to_evt),
  .b_to_evt   (b_to_evt),
  .b_match_evt(b_match_evt),
  .ctrl_we    (ctrl_we),
  .clr_we     (clr_we),
  .ld_a_we    (ld_a_we),
  .ld_b_we    (ld_b_we),
  .wr_data_i  (wr_data_i),
  .cnt_a_o    (cnt_a_o),
  .cnt_b_o    (cnt_b_o),
  .raw_o      (raw_o)
);

// File: tb/duo_timer_tb_top.sv
module duo_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cap_a = 1'b0, cap_b = 1'b0, rtc_in = 1'b0;
  logic [15:0] cnt_a, cnt_b;
  logic [3:0]  raw, mis;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // register map (R14)
  localparam logic [3:0] CFG = 0, CTRL = 1, MODE_A = 2, MODE_B = 3,
    LOAD_A = 4, LOAD_B = 5, MATCH_A = 6, MATCH_B = 7, PRE_A = 8, PRE_B = 9,
    PM_A = 10, PM_B = 11, MASK = 12, CLR = 13;

  always #5 clk = ~clk;

  duo_timer #(.RTC_DIV(4)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .cap_a_i  (cap_a),
    .cap_b_i  (cap_b),
    .rtc_in_i (rtc_in),
    .cnt_a_o  (cnt_a),
    .cnt_b_o  (cnt_b),
    .raw_o    (raw),
    .mis_o    (mis),
    .irq_o    (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(ref logic pin, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pin = 1'b1;
      repeat (3) @(negedge clk);
      pin = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic quiesce();
    wr(CTRL, 16'h0); wr(CFG, 16'h0); wr(MASK, 16'h0); wr(CLR, 16'hF);
  endtask

  task automatic t_reset();
    chk("R1 cnt_a", cnt_a, 32'hFFFF);
    chk("R1 cnt_b", cnt_b, 32'hFFFF);
    chk("R1 raw", raw, 0);
    chk("R1 mis", mis, 0);
    chk("R1 irq", irq, 0);
    cycles(10);
    chk("R2 idle a", cnt_a, 32'hFFFF);
    chk("R2 idle b", cnt_b, 32'hFFFF);
  endtask

  task automatic t_oneshot();
    quiesce();
    wr(MODE_A, 16'd0); wr(PRE_A, 16'd0); wr(PM_A, 16'd0); wr(MATCH_A, 16'd9);
    wr(LOAD_A, 16'd5);
    chk("R6 load write", cnt_a, 5);
    wr(CLR, 16'hF);
    wr(CTRL, 16'h1);
    chk("R3 no step yet", cnt_a, 5);
    cycles(5);
    chk("R3 stepped to 0", cnt_a, 0);
    chk("R4 no timeout yet", raw[0], 0);
    cycles(1);
    chk("R4 timeout", raw[0], 1);
    chk("R4 held at 0", cnt_a, 0);
    wr(LOAD_A, 16'd2);
    cycles(3);
    chk("R4 enable cleared", cnt_a, 2);
  endtask

  task automatic t_periodic_b();
    quiesce();
    wr(LOAD_A, 16'h1234);
    wr(MODE_B, 16'd1); wr(PRE_B, 16'd2); wr(PM_B, 16'd0); wr(MATCH_B, 16'h7777);
    wr(LOAD_B, 16'd3);
    wr(CTRL, 16'h2);
    cycles(2);
    chk("R3 prescale wait", cnt_b, 3);
    cycles(1);
    chk("R3 prescale step", cnt_b, 2);
    cycles(6);
    chk("R3 reached 0", cnt_b, 0);
    chk("R5 no timeout yet", raw[2], 0);
    cycles(3);
    chk("R5 timeout b", raw[2], 1);
    chk("R5 reload b", cnt_b, 3);
    chk("R7 a untouched", cnt_a, 32'h1234);
    chk("R7 a no status", raw[1:0], 0);
  endtask

  task automatic t_match();
    quiesce();
    wr(MODE_A, 16'd1); wr(PRE_A, 16'd0); wr(PM_A, 16'd0);
    wr(MATCH_A, 16'd7); wr(LOAD_A, 16'd10); wr(MASK, 16'h2); wr(CLR, 16'hF);
    wr(CTRL, 16'h1);
    cycles(3);
    chk("R9 cnt at match", cnt_a, 7);
    chk("R9 no hit yet", raw[1], 0);
    chk("R12 irq low", irq, 0);
    cycles(1);
    chk("R9 hit", raw[1], 1);
    chk("R12 mis", mis, 4'h2);
    chk("R12 irq high", irq, 1);
    wr(MASK, 16'h0);
    chk("R12 masked off", irq, 0);
    // prescale compare
    wr(CTRL, 16'h0);
    wr(PRE_A, 16'd3); wr(PM_A, 16'd2); wr(MATCH_A, 16'd9); wr(LOAD_A, 16'd10);
    wr(CLR, 16'hF);
    wr(CTRL, 16'h1);
    cycles(6);
    chk("R9 pre-match wait", raw[1], 0);
    chk("R9 cnt 9", cnt_a, 9);
    cycles(1);
    chk("R9 pre-match hit", raw[1], 1);
  endtask

  task automatic t_clear();
    quiesce();
    wr(MODE_A, 16'd1); wr(PRE_A, 16'd0); wr(PM_A, 16'd0);
    wr(MATCH_A, 16'd0); wr(LOAD_A, 16'd0);
    wr(CTRL, 16'h1);
    cycles(2);
    wr(CLR, 16'h1);
    chk("R13 event wins", raw[0], 1);
    wr(CTRL, 16'h0);
    chk("R13 both set", raw[1:0], 2'b11);
    wr(CLR, 16'h1);
    chk("R13 clear bit0 only", raw[1:0], 2'b10);
  endtask

  task automatic t_joined();
    quiesce();
    wr(CFG, 16'd1);
    wr(MODE_A, 16'd1); wr(PRE_A, 16'd0); wr(PM_A, 16'd0);
    wr(MATCH_A, 16'h5555); wr(MATCH_B, 16'h5555);
    wr(LOAD_A, 16'd1); wr(LOAD_B, 16'd1);
    wr(CTRL, 16'h1);
    cycles(1);
    chk("R8 a to 0", cnt_a, 0);
    chk("R8 b held", cnt_b, 1);
    cycles(1);
    chk("R8 a wraps", cnt_a, 32'hFFFF);
    chk("R8 b borrows", cnt_b, 0);
    wr(CTRL, 16'h0);
    wr(LOAD_A, 16'd2); wr(LOAD_B, 16'd0); wr(CLR, 16'hF);
    wr(CTRL, 16'h1);
    cycles(2);
    chk("R8 wide 0", {cnt_b, cnt_a}, 0);
    chk("R8 no timeout yet", raw[0], 0);
    cycles(1);
    chk("R8 timeout", raw[0], 1);
    chk("R8 reload", {cnt_b, cnt_a}, 2);
    chk("R8 b bits quiet", raw[3:2], 0);
  endtask

  task automatic t_edge();
    quiesce();
    wr(MODE_A, 16'd2); wr(PRE_A, 16'd0); wr(PM_A, 16'd0); wr(LOAD_A, 16'd100);
    wr(CTRL, 16'h1);
    cycles(10);
    chk("R10 clocks ignored", cnt_a, 100);
    pulse(cap_a, 4);
    cycles(5);
    chk("R10 edges counted", cnt_a, 96);
  endtask

  task automatic t_rtc();
    quiesce();
    wr(CFG, 16'd2);
    wr(MODE_A, 16'd1); wr(PRE_A, 16'd0); wr(LOAD_A, 16'd3); wr(LOAD_B, 16'd0);
    wr(CTRL, 16'h1);
    cycles(10);
    chk("R11 no rtc no step", cnt_a, 3);
    pulse(rtc_in, 8);
    cycles(5);
    chk("R11 two steps", cnt_a, 1);
    pulse(rtc_in, 4);
    cycles(5);
    chk("R11 third step", cnt_a, 0);
    chk("R11 upper", cnt_b, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_oneshot();
    t_periodic_b();
    t_match();
    t_clear();
    t_joined();
    t_edge();
    t_rtc();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule